// File: doc/BRIEF.md
# External Bus Arbiter

This block decides who owns a shared external bus at any moment: the on-chip master or a single off-chip master. The on-chip side presents a request-pending level and a transfer-start strobe. The off-chip side presents an active-low request. Both sides watch a shared, open bus-busy pin. The arbiter answers with an active-low grant to the off-chip master. It also drives the busy pin through a value and an output enable while the on-chip master owns the bus.

Ownership passes through short wait states into owning states. When both sides ask at once from idle, a priority bit settles the contest, and that bit is handed to the other side after every completed ownership. When the on-chip master lets go of the busy pin, it first drives the pin high for one cycle so the line is actively negated, and only then releases it. After any off-chip grant, a reservation window of a few cycles keeps the grant asserted, so the off-chip master has time to take the bus. Once a wait state is entered, request withdrawal by either side is ignored.

Top module: `extBusArbiter`

## Requirements
- R1: A synchronous active-high reset puts the block in idle: `bgN` high, `bbOe` low, `bbOut` high, and priority with the on-chip master.
- R2: In idle, an on-chip request is sampled at a clock edge while `bbIn` is high, no off-chip request wins, and no window is active. The block then spends one wait cycle with `bbOe` low, and drives the pin low (`bbOe`=1, `bbOut`=0) from the cycle after that.
- R3: If `intReqPend` is dropped during the on-chip wait cycle, it has no effect: the pin is still driven low for at least one cycle before release begins.
- R4: When `intReqPend` is sampled low while the pin is driven low, the next cycle drives `bbOut`=1 with `bbOe`=1. This high drive lasts exactly one cycle. After it, `bbOe` goes low and the block returns to idle, unless R5 applies.
- R5: If `intReqPend` and `intXferStart` are both high at the end of the one-cycle high drive, the pin is driven low again in the next cycle and `bbOe` never drops.
- R6: `intXferStart` has no effect on any output except at the end of the one-cycle high drive.
- R7: In idle, an off-chip request (`brN`=0) that wins arbitration makes `bgN` go low in the next cycle. `bgN` stays low through the off-chip wait and owning states.
- R8: If `brN` returns high after the grant, it has no effect. `bgN` stays low until `bbIn` is high and the reservation window has expired.
- R9: The reservation window covers the WIN_CYCLES (default 3) cycles that follow the first cycle of `bgN` low. As a result, `bgN` stays low for at least WIN_CYCLES+2 cycles.
- R10: The on-chip master is never granted from idle while `bbIn` is sampled low or the reservation window is active.
- R11: When both sides request in idle, the on-chip master wins if the priority bit is 0 and the off-chip master wins if it is 1. Priority passes to the off-chip side when on-chip ownership ends, and to the on-chip side when off-chip ownership ends.
- R12: `bgN` low and `bbOe` high never occur in the same cycle, and the on-chip master is never busy while the grant is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| intReqPend | input | 1 | On-chip master has a pending bus request |
| intXferStart | input | 1 | On-chip master is starting a transfer this cycle |
| brN | input | 1 | Off-chip bus request, active low |
| bbIn | input | 1 | Sampled level of the shared busy pin (low = busy) |
| bgN | output | 1 | Bus grant to the off-chip master, active low |
| bbOut | output | 1 | Value driven onto the busy pin when enabled |
| bbOe | output | 1 | Output enable for the busy pin |

## Verification
The bench drops the on-chip request inside its wait cycle. A design that honoured the drop would skip the low drive or fall back to idle. It also raises a new request together with a transfer start during the one-cycle high drive, which catches a design that releases the pin anyway or leaves the high drive in place. Off-chip grants are withdrawn immediately and held without ever taking the bus, so a missing or miscounted reservation window shows up as `bgN` rising too early. Simultaneous requests are repeated with the priority bit in each setting, which exposes a stuck or inverted priority. The bench also holds `bbIn` low to confirm that an on-chip grant stays blocked.

// File: rtl/arbPkg.sv
package arbPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MCU_WAIT,
    ST_MCU_OWN,
    ST_EXT_WAIT,
    ST_EXT_OWN
  } arbState_e;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic busLow;    // drive busy pin low
    logic busHigh;   // drive busy pin high (active negate)
    logic busFree;   // turn the pin driver off
    logic giveExt;   // hand priority to the off-chip master
    logic giveMcu;   // hand priority to the on-chip master
  } arbStrobe_t;

endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import arbPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       intReqPend,
  input  logic       intXferStart,
  input  logic       extReq,
  input  logic       bbIn,
  input  logic       winActive,
  input  logic       prioExt,
  output arbStrobe_t strobe,
  output logic       bgN,
  output logic       mcuBusy
);

  arbState_e state, nextState;
  logic      negPhase, nextNeg;
  logic      intOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      negPhase <= 1'b0;
    end else begin
      state    <= nextState;
      negPhase <= nextNeg;
    end
  end

  assign intOk = intReqPend && bbIn && !winActive;

  always_comb begin
    nextState = state;
    nextNeg   = negPhase;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (extReq && (prioExt || !intOk)) begin
          nextState = ST_EXT_WAIT;
        end else if (intOk) begin
          nextState = ST_MCU_WAIT;
        end
      end
      ST_MCU_WAIT: begin
        // request level deliberately not examined here
        nextState     = ST_MCU_OWN;
        nextNeg       = 1'b0;
        strobe.busLow = 1'b1;
      end
      ST_MCU_OWN: begin
        if (!negPhase) begin
          if (!intReqPend) begin
            nextNeg        = 1'b1;
            strobe.busHigh = 1'b1;
          end
        end else if (intReqPend && intXferStart) begin
          nextNeg       = 1'b0;
          strobe.busLow = 1'b1;
        end else begin
          nextNeg        = 1'b0;
          nextState      = ST_IDLE;
          strobe.busFree = 1'b1;
          strobe.giveExt = 1'b1;
        end
      end
      ST_EXT_WAIT: begin
        // off-chip request level deliberately not examined here
        nextState = ST_EXT_OWN;
      end
      ST_EXT_OWN: begin
        if (bbIn && !winActive) begin
          nextState      = ST_IDLE;
          strobe.giveMcu = 1'b1;
        end
      end
      default: begin
        nextState = ST_IDLE;
        nextNeg   = 1'b0;
      end
    endcase
  end

  assign bgN     = !(state == ST_EXT_WAIT || state == ST_EXT_OWN);
  assign mcuBusy = (state == ST_MCU_WAIT) || (state == ST_MCU_OWN);

endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int WIN_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  arbStrobe_t strobe,
  input  logic       bgN,
  output logic       bbOut,
  output logic       bbOe,
  output logic       prioExt,
  output logic       winActive
);

  localparam int CNT_W = $clog2(WIN_CYCLES + 1);

  logic [CNT_W-1:0] winCnt;
  logic             bgPrev;

  // busy pin driver
  always_ff @(posedge clk) begin
    if (rst) begin
      bbOut <= 1'b1;
      bbOe  <= 1'b0;
    end else if (strobe.busLow) begin
      bbOut <= 1'b0;
      bbOe  <= 1'b1;
    end else if (strobe.busHigh) begin
      bbOut <= 1'b1;
      bbOe  <= 1'b1;
    end else if (strobe.busFree) begin
      bbOut <= 1'b1;
      bbOe  <= 1'b0;
    end
  end

  // priority bit: 0 = on-chip side first, 1 = off-chip side first
  always_ff @(posedge clk) begin
    if (rst) begin
      prioExt <= 1'b0;
    end else if (strobe.giveExt) begin
      prioExt <= 1'b1;
    end else if (strobe.giveMcu) begin
      prioExt <= 1'b0;
    end
  end

  // reservation window, started by the falling edge of the grant
  always_ff @(posedge clk) begin
    if (rst) begin
      bgPrev <= 1'b1;
      winCnt <= '0;
    end else begin
      bgPrev <= bgN;
      if (!bgN && bgPrev) begin
        winCnt <= CNT_W'(WIN_CYCLES);
      end else if (winCnt != '0) begin
        winCnt <= winCnt - CNT_W'(1);
      end
    end
  end

  assign winActive = (winCnt != '0);

endmodule

// File: rtl/extBusArbiter.sv
module extBusArbiter
  import arbPkg::*;
#(
  parameter int WIN_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic intReqPend,
  input  logic intXferStart,
  input  logic brN,
  input  logic bbIn,
  output logic bgN,
  output logic bbOut,
  output logic bbOe
);

  arbStrobe_t strobe;
  logic       winActive;
  logic       prioExt;
  logic       mcuBusy;

  arbCtrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .intReqPend  (intReqPend),
    .intXferStart(intXferStart),
    .extReq      (!brN),
    .bbIn        (bbIn),
    .winActive   (winActive),
    .prioExt     (prioExt),
    .strobe      (strobe),
    .bgN         (bgN),
    .mcuBusy     (mcuBusy)
  );

  arbDatapath #(.WIN_CYCLES(WIN_CYCLES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .bgN      (bgN),
    .bbOut    (bbOut),
    .bbOe     (bbOe),
    .prioExt  (prioExt),
    .winActive(winActive)
  );

endmodule

// File: rtl/arbChecker.sv
module arbChecker #(
  parameter int WIN_CYCLES = 3
) (
  input logic clk,
  input logic rst,
  input logic bbIn,
  input logic bgN,
  input logic bbOut,
  input logic bbOe,
  input logic mcuBusy,
  input logic winActive
);

  localparam int LIM = WIN_CYCLES + 2;
  localparam int CW  = $clog2(LIM + 1) + 1;

  logic [CW-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (rst || bgN) begin
      lowCnt <= '0;
    end else if (lowCnt != CW'(LIM)) begin
      lowCnt <= lowCnt + CW'(1);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (bgN && !bbOe && !mcuBusy));

  assert_wait_then_low_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(mcuBusy) && !$past(rst)) |=> (bbOe && !bbOut));

  assert_no_direct_release_R4: assert property (@(posedge clk) disable iff (rst)
    (bbOe && !bbOut) |=> bbOe);

  assert_single_high_R4: assert property (@(posedge clk) disable iff (rst)
    (bbOe && bbOut) |=> !(bbOe && bbOut));

  assert_min_grant_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(bgN) && !$past(rst)) |-> (lowCnt >= CW'(LIM)));

  assert_int_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    ($rose(mcuBusy) && !$past(rst)) |-> ($past(bbIn) && !$past(winActive)));

  assert_no_clash_R12: assert property (@(posedge clk) disable iff (rst)
    !bgN |-> (!bbOe && !mcuBusy));

endmodule

bind extBusArbiter arbChecker #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bbIn     (bbIn),
  .bgN      (bgN),
  .bbOut    (bbOut),
  .bbOe     (bbOe),
  .mcuBusy  (mcuBusy),
  .winActive(winActive)
);

// File: tb/extBusArbiter_bench.sv
`timescale 1ns/1ps
module extBusArbiter_bench;

  localparam int WIN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic intReqPend = 1'b0;
  logic intXferStart = 1'b0;
  logic brN = 1'b1;
  logic bbIn = 1'b1;
  logic bgN, bbOut, bbOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string curTag = "R1";

  // behavioural reference: 0 idle,1 mcu wait,2 mcu own,3 ext wait,4 ext own
  int mSt, mNeg, mPrio, mWin, mBgPrev;

  always #10 clk = ~clk;

  extBusArbiter #(.WIN_CYCLES(WIN)) u_extBusArbiter (
    .clk(clk), .rst(rst), .intReqPend(intReqPend), .intXferStart(intXferStart),
    .brN(brN), .bbIn(bbIn), .bgN(bgN), .bbOut(bbOut), .bbOe(bbOe)
  );

  function automatic logic expBg();
    return (mSt == 3 || mSt == 4) ? 1'b0 : 1'b1;
  endfunction
  function automatic logic expOe();
    return (mSt == 2) ? 1'b1 : 1'b0;
  endfunction
  function automatic logic expOut();
    return (mSt == 2) ? logic'(mNeg != 0) : 1'b1;
  endfunction

  task automatic modelReset();
    mSt = 0; mNeg = 0; mPrio = 0; mWin = 0; mBgPrev = 1;
  endtask

  task automatic compareAll();
    checks++;
    if (bgN !== expBg() || bbOe !== expOe() || bbOut !== expOut()) begin
      errors++;
      $display("FAIL %s: bgN/bbOe/bbOut actual %b%b%b expected %b%b%b (t=%0t)",
               curTag, bgN, bbOe, bbOut, expBg(), expOe(), expOut(), $time);
    end
    checks++;  // R12 exclusivity at the ports
    if (!bgN && bbOe) begin
      errors++;
      $display("FAIL R12: bgN=%b bbOe=%b expected not both active", bgN, bbOe);
    end
  endtask

  task automatic step(input logic rq, input logic xs, input logic br, input logic bb);
    int nSt, nNeg, nPrio, nWin;
    logic win, bg, intOk;
    intReqPend = rq; intXferStart = xs; brN = br; bbIn = bb;
    win = (mWin != 0);
    bg = expBg();
    nSt = mSt; nNeg = mNeg; nPrio = mPrio;
    if (!bg && mBgPrev != 0) nWin = WIN;
    else nWin = (mWin > 0) ? mWin - 1 : 0;
    case (mSt)
      0: begin
        intOk = rq && bb && !win;
        if (!br && (mPrio != 0 || !intOk)) nSt = 3;
        else if (intOk) nSt = 1;
      end
      1: begin nSt = 2; nNeg = 0; end
      2: begin
        if (mNeg == 0) begin
          if (!rq) nNeg = 1;
        end else if (rq && xs) nNeg = 0;
        else begin nNeg = 0; nSt = 0; nPrio = 1; end
      end
      3: nSt = 4;
      default: if (bb && !win) begin nSt = 0; nPrio = 0; end
    endcase
    @(posedge clk);
    mSt = nSt; mNeg = nNeg; mPrio = nPrio; mWin = nWin; mBgPrev = int'(bg);
    @(negedge clk);
    compareAll();
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    modelReset();
    @(negedge clk);
    rst = 1'b0;
    curTag = "R1";
    compareAll();
    checks++;
    if (bgN !== 1'b1 || bbOe !== 1'b0 || bbOut !== 1'b1) begin
      errors++;
      $display("FAIL R1: reset outputs %b%b%b expected 101", bgN, bbOe, bbOut);
    end
  endtask

  task automatic mcuBurst(input int hold);
    step(1, 0, 1, 1);
    for (int i = 0; i < hold; i++) step(1, 0, 1, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1);
  endtask

  initial begin
    modelReset();
    repeat (2) @(posedge clk);
    applyReset();

    curTag = "R2"; mcuBurst(3);
    curTag = "R4"; step(0, 0, 1, 1); step(0, 0, 1, 1);

    // R5: re-request with transfer start during the high drive
    curTag = "R5";
    step(1, 0, 1, 1); step(1, 0, 1, 1); step(1, 0, 1, 1);
    step(0, 0, 1, 1);               // request drops, high drive next
    step(1, 1, 1, 1);               // sampled at end of high-drive cycle
    checks++;
    if (bbOe !== 1'b1 || bbOut !== 1'b0) begin
      errors++;
      $display("FAIL R5: bbOe/bbOut %b%b expected 10", bbOe, bbOut);
    end
    step(1, 0, 1, 1); step(0, 0, 1, 1);
    step(0, 0, 1, 1); step(0, 0, 1, 1);

    // R3: request dropped during the wait cycle
    curTag = "R3";
    step(1, 0, 1, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1);

    // R6: transfer start in idle and while owning
    curTag = "R6";
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1);
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1);
    step(0, 1, 1, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1);

    // R7 / R9: off-chip master alone (priority now off-chip)
    curTag = "R7";
    step(0, 0, 0, 1);
    checks++;
    if (bgN !== 1'b0) begin
      errors++;
      $display("FAIL R7: bgN %b expected 0", bgN);
    end
    step(0, 0, 0, 1); step(0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    curTag = "R9";
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1);

    // R8 / R9: grant taken back at once, bus never used
    curTag = "R8";
    step(0, 0, 0, 1);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 1, 1);
      checks++;
      if (bgN !== 1'b0) begin
        errors++;
        $display("FAIL R8: bgN %b expected 0 in window", bgN);
      end
    end
    curTag = "R9";
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1);

    // R11: both request with priority on-chip, then off-chip
    curTag = "R11";
    step(1, 0, 0, 1);
    checks++;
    if (bgN !== 1'b1) begin
      errors++;
      $display("FAIL R11: bgN %b expected 1 (on-chip wins)", bgN);
    end
    step(1, 0, 0, 1); step(1, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1);
    mcuBurst(1);                       // priority handed to off-chip
    step(1, 0, 0, 1);
    checks++;
    if (bgN !== 1'b0) begin
      errors++;
      $display("FAIL R11: bgN %b expected 0 (off-chip wins)", bgN);
    end
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 1, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1);

    // R10: busy pin low blocks the on-chip grant
    curTag = "R10";
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 1, 0);
      checks++;
      if (bbOe !== 1'b0) begin
        errors++;
        $display("FAIL R10: bbOe %b expected 0 while pin busy", bbOe);
      end
    end
    mcuBurst(2);

    // R1: reset while owning the bus
    step(1, 0, 1, 1); step(1, 0, 1, 1); step(1, 0, 1, 1);
    applyReset();
    curTag = "R2"; mcuBurst(1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule